// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block brings a DDR-style memory from power-on to a usable state. After a synchronous reset it holds the memory deselected with the clock-enable pin low. It then waits for an external signal saying the supply and clock have been stable for the required settling time. Once that signal is seen, it drives one clock of NOP with the clock enable raised. It then issues a precharge of all banks, two auto-refresh commands and a mode-register load, in that order.

After each command the block drives only NOPs until the memory's timing for that command has elapsed. The number of NOP cycles is computed at elaboration from the clock period and the three delays (precharge, refresh cycle, mode-register set) as ceil(delay/period) - 1. When that count is zero the wait is dropped and the next command follows in the very next clock.

When the last delay has expired the block raises a done flag. It then holds the pins at NOP until the next reset. All pin outputs are registered, so each one changes only on a clock edge.

Top module: `dram_init_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `cke_o` is 0, `init_done_o` is 0, `addr_o` and `ba_o` are all zeros, and the command pins {`cs_n_o`,`ras_n_o`,`cas_n_o`,`we_n_o`} read 4'b1111 (deselect).
- R2: After reset, as long as `stable_i` is sampled low, the outputs keep their R1 values.
- R3: The first clock edge that samples `stable_i` high starts one cycle of NOP with `cke_o` high. The precharge command follows in the next cycle.
- R4: The command pins use these encodings of {cs_n,ras_n,cas_n,we_n}: NOP 4'b0111, precharge 4'b0010, auto refresh 4'b0001, mode-register load 4'b0000. The commands appear in the order precharge, auto refresh, auto refresh, mode-register load.
- R5: Each command is followed by exactly ceil(t/T_CK)-1 NOP cycles before the next step. Here t is T_RP after the precharge, T_RFC after each refresh and T_MRD after the mode load. The step after the mode load's wait is the ready state.
- R6: When a computed wait count is zero, the next command, or the ready state, comes in the clock right after the command.
- R7: During the precharge command, `addr_o` has only bit 10 set and `ba_o` is zero.
- R8: During the mode-register load, `addr_o` equals the `MODE_VALUE` parameter and `ba_o` is zero.
- R9: `init_done_o` rises in the first cycle of the ready state and then stays high, with NOP on the command pins and `cke_o` high, until reset. Changes on `stable_i` have no effect once it is high.
- R10: A reset at any point in the sequence returns the outputs to their R1 values at the next edge. The sequence then starts again from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stable_i | input | 1 | Power and clock settling time has elapsed |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Memory address bus |
| ba_o | output | BANK_W | Bank address |
| init_done_o | output | 1 | Initialization complete |

## Verification
The hardest case to reach is the zero-length wait. No single timing set makes every wait collapse while others still run. The bench therefore drives a second instance whose precharge and mode-load delays fit within one clock and whose refresh delay does not, so that back-to-back commands and a stretched gap are seen in the same sequence. A reset in the middle of a refresh wait is the other hard case. It is reached by counting clocks from the stabilization edge and asserting reset while the timer is still running, then checking that the sequence restarts cleanly from the idle state.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAKE,
        ST_PRE,
        ST_PRE_W,
        ST_REF1,
        ST_REF1_W,
        ST_REF2,
        ST_REF2_W,
        ST_MODE,
        ST_MODE_W,
        ST_READY
    } init_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_cmd_t;

    localparam dram_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam dram_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam dram_cmd_t CMD_PRE   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam dram_cmd_t CMD_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam dram_cmd_t CMD_MRS   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    // Address bit that selects "all banks" on a precharge.
    localparam int PRE_ALL_BIT = 10;

    // NOP cycles needed after a command: ceil(t/tck) - 1, never negative.
    function automatic int wait_clocks(input int t_ps, input int tck_ps);
        int whole;
        whole = (t_ps + tck_ps - 1) / tck_ps;
        return (whole > 0) ? whole - 1 : 0;
    endfunction

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Timer width, at least one bit even when every wait is skipped.
    function automatic int timer_width(input int max_count);
        int w;
        w = $clog2(max_count + 1);
        return (w < 1) ? 1 : w;
    endfunction

    // Pin pattern that belongs to each sequencer state.
    function automatic dram_cmd_t cmd_for_state(input init_state_e s);
        dram_cmd_t c;
        case (s)
            ST_IDLE:          c = CMD_DESEL;
            ST_PRE:           c = CMD_PRE;
            ST_REF1, ST_REF2: c = CMD_REF;
            ST_MODE:          c = CMD_MRS;
            default:          c = CMD_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dram_init_timer.sv
module dram_init_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The wait state holds while the count runs; it leaves when one cycle is left.
    assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/dram_init_fsm.sv
module dram_init_fsm
    import dram_init_pkg::*;
#(
    parameter int WAIT_RP  = 2,
    parameter int WAIT_RFC = 9,
    parameter int WAIT_MRD = 1,
    parameter int CW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stable_i,
    input  logic          timer_last_i,
    output init_state_e   state_d_o,
    output logic          load_o,
    output logic [CW-1:0] load_val_o
);
    localparam logic SKIP_RP  = (WAIT_RP  == 0);
    localparam logic SKIP_RFC = (WAIT_RFC == 0);
    localparam logic SKIP_MRD = (WAIT_MRD == 0);

    localparam logic [CW-1:0] LV_RP  = CW'(WAIT_RP);
    localparam logic [CW-1:0] LV_RFC = CW'(WAIT_RFC);
    localparam logic [CW-1:0] LV_MRD = CW'(WAIT_MRD);

    init_state_e state_q;
    init_state_e state_d;

    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = '0;
        case (state_q)
            ST_IDLE:   if (stable_i) state_d = ST_WAKE;
            ST_WAKE:   state_d = ST_PRE;
            ST_PRE: begin
                state_d    = SKIP_RP ? ST_REF1 : ST_PRE_W;
                load_o     = !SKIP_RP;
                load_val_o = LV_RP;
            end
            ST_PRE_W:  if (timer_last_i) state_d = ST_REF1;
            ST_REF1: begin
                state_d    = SKIP_RFC ? ST_REF2 : ST_REF1_W;
                load_o     = !SKIP_RFC;
                load_val_o = LV_RFC;
            end
            ST_REF1_W: if (timer_last_i) state_d = ST_REF2;
            ST_REF2: begin
                state_d    = SKIP_RFC ? ST_MODE : ST_REF2_W;
                load_o     = !SKIP_RFC;
                load_val_o = LV_RFC;
            end
            ST_REF2_W: if (timer_last_i) state_d = ST_MODE;
            ST_MODE: begin
                state_d    = SKIP_MRD ? ST_READY : ST_MODE_W;
                load_o     = !SKIP_MRD;
                load_val_o = LV_MRD;
            end
            ST_MODE_W: if (timer_last_i) state_d = ST_READY;
            ST_READY:  state_d = ST_READY;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_d_o = state_d;

endmodule

// File: rtl/dram_init_pins.sv
module dram_init_pins
    import dram_init_pkg::*;
#(
    parameter int                ADDR_W     = 13,
    parameter int                BANK_W     = 2,
    parameter logic [ADDR_W-1:0] MODE_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  init_state_e       state_d_i,
    output dram_cmd_t         cmd_o,
    output logic              cke_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] ba_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1) << PRE_ALL_BIT;

    dram_cmd_t         cmd_d;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        cmd_d = cmd_for_state(state_d_i);
        case (state_d_i)
            ST_PRE:  addr_d = PRE_ALL_ADDR;
            ST_MODE: addr_d = MODE_VALUE;
            default: addr_d = '0;
        endcase
    end

    // Registered pins follow the state register with the same timing.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o  <= CMD_DESEL;
            cke_o  <= 1'b0;
            addr_o <= '0;
            ba_o   <= '0;
            done_o <= 1'b0;
        end else begin
            cmd_o  <= cmd_d;
            cke_o  <= (state_d_i != ST_IDLE);
            addr_o <= addr_d;
            ba_o   <= '0;
            done_o <= (state_d_i == ST_READY);
        end
    end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int                CLK_PERIOD_PS = 8000,
    parameter int                T_RP_PS       = 20000,
    parameter int                T_RFC_PS      = 75000,
    parameter int                T_MRD_PS      = 12000,
    parameter int                ADDR_W        = 13,
    parameter int                BANK_W        = 2,
    parameter logic [ADDR_W-1:0] MODE_VALUE    = 13'h0032
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stable_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] ba_o,
    output logic              init_done_o
);
    localparam int WAIT_RP  = wait_clocks(T_RP_PS,  CLK_PERIOD_PS);
    localparam int WAIT_RFC = wait_clocks(T_RFC_PS, CLK_PERIOD_PS);
    localparam int WAIT_MRD = wait_clocks(T_MRD_PS, CLK_PERIOD_PS);
    localparam int WAIT_MAX = max_of3(WAIT_RP, WAIT_RFC, WAIT_MRD);
    localparam int CW       = timer_width(WAIT_MAX);

    init_state_e   state_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_last;
    dram_cmd_t     cmd;

    dram_init_fsm #(
        .WAIT_RP  (WAIT_RP),
        .WAIT_RFC (WAIT_RFC),
        .WAIT_MRD (WAIT_MRD),
        .CW       (CW)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .stable_i     (stable_i),
        .timer_last_i (tmr_last),
        .state_d_o    (state_d),
        .load_o       (tmr_load),
        .load_val_o   (tmr_val)
    );

    dram_init_timer #(
        .CW (CW)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .last_o     (tmr_last)
    );

    dram_init_pins #(
        .ADDR_W     (ADDR_W),
        .BANK_W     (BANK_W),
        .MODE_VALUE (MODE_VALUE)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .state_d_i (state_d),
        .cmd_o     (cmd),
        .cke_o     (cke_o),
        .addr_o    (addr_o),
        .ba_o      (ba_o),
        .done_o    (init_done_o)
    );

    assign cs_n_o  = cmd.cs_n;
    assign ras_n_o = cmd.ras_n;
    assign cas_n_o = cmd.cas_n;
    assign we_n_o  = cmd.we_n;

endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk
    import dram_init_pkg::*;
#(
    parameter int                CLK_PERIOD_PS = 8000,
    parameter int                T_RP_PS       = 20000,
    parameter int                T_RFC_PS      = 75000,
    parameter int                T_MRD_PS      = 12000,
    parameter int                ADDR_W        = 13,
    parameter int                BANK_W        = 2,
    parameter logic [ADDR_W-1:0] MODE_VALUE    = 13'h0032
) (
    input logic              clk,
    input logic              rst,
    input logic              stable_i,
    input logic              cke_o,
    input logic              cs_n_o,
    input logic              ras_n_o,
    input logic              cas_n_o,
    input logic              we_n_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [BANK_W-1:0] ba_o,
    input logic              init_done_o
);
    localparam int NEED_RP  = wait_clocks(T_RP_PS,  CLK_PERIOD_PS) + 1;
    localparam int NEED_RFC = wait_clocks(T_RFC_PS, CLK_PERIOD_PS) + 1;
    localparam int NEED_MRD = wait_clocks(T_MRD_PS, CLK_PERIOD_PS) + 1;
    localparam logic [ADDR_W-1:0] A10 = ADDR_W'(1) << PRE_ALL_BIT;

    localparam logic [1:0] K_NONE = 2'd0;
    localparam logic [1:0] K_PRE  = 2'd1;
    localparam logic [1:0] K_REF  = 2'd2;
    localparam logic [1:0] K_MRS  = 2'd3;

    dram_cmd_t   cmd;
    logic        is_pre, is_ref, is_mrs, is_cmd;
    logic [1:0]  last_kind;
    logic [1:0]  ref_cnt;
    logic [15:0] gap;

    assign cmd    = '{cs_n: cs_n_o, ras_n: ras_n_o, cas_n: cas_n_o, we_n: we_n_o};
    assign is_pre = (cmd == CMD_PRE);
    assign is_ref = (cmd == CMD_REF);
    assign is_mrs = (cmd == CMD_MRS);
    assign is_cmd = is_pre | is_ref | is_mrs;

    // Observed command history: kind of the last command and clocks since it.
    always_ff @(posedge clk) begin
        if (rst) begin
            last_kind <= K_NONE;
            ref_cnt   <= '0;
            gap       <= '0;
        end else begin
            if (is_cmd) begin
                gap <= 16'd1;
            end else if (gap != 16'hFFFF) begin
                gap <= gap + 16'd1;
            end
            if (is_pre) last_kind <= K_PRE;
            if (is_ref) begin
                last_kind <= K_REF;
                ref_cnt   <= ref_cnt + 2'd1;
            end
            if (is_mrs) last_kind <= K_MRS;
        end
    end

    a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cke_o && cmd == CMD_DESEL && addr_o == '0 && ba_o == '0 && !init_done_o));

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!cke_o && !stable_i) |=> (!cke_o && cmd == CMD_DESEL));

    a_r3_wake_then_pre: assert property (@(posedge clk) disable iff (rst)
        (!cke_o && stable_i) |=> (cke_o && cmd == CMD_NOP) ##1 (cmd == CMD_PRE));

    a_r4_pre_first: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> (last_kind == K_NONE));

    a_r4_mode_after_two_refresh: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (last_kind == K_REF && ref_cnt == 2'd2));

    a_r5_gap_after_pre: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && last_kind == K_PRE) |-> (gap >= 16'(NEED_RP)));

    a_r5_gap_after_ref: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && last_kind == K_REF) |-> (gap >= 16'(NEED_RFC)));

    a_r5_gap_before_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done_o) |-> (last_kind == K_MRS && gap >= 16'(NEED_MRD)));

    a_r7_pre_addr: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> (addr_o == A10 && ba_o == '0));

    a_r8_mode_addr: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (addr_o == MODE_VALUE && ba_o == '0));

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done_o |=> init_done_o);

    a_r9_ready_quiet: assert property (@(posedge clk) disable iff (rst)
        init_done_o |-> (cke_o && cmd == CMD_NOP));

endmodule

bind dram_init_seq dram_init_seq_chk #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .T_RP_PS       (T_RP_PS),
    .T_RFC_PS      (T_RFC_PS),
    .T_MRD_PS      (T_MRD_PS),
    .ADDR_W        (ADDR_W),
    .BANK_W        (BANK_W),
    .MODE_VALUE    (MODE_VALUE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stable_i    (stable_i),
    .cke_o       (cke_o),
    .cs_n_o      (cs_n_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .we_n_o      (we_n_o),
    .addr_o      (addr_o),
    .ba_o        (ba_o),
    .init_done_o (init_done_o)
);

// File: tb/dram_init_seq_bench.sv
`timescale 1ns/1ps
module dram_init_seq_bench;

    localparam logic [12:0] MODE = 13'h0032;
    localparam logic [3:0] C_DES = 4'b1111;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    // Main instance: tCK 8 ns, tRP 20 ns -> 2 NOPs, tRFC 75 ns -> 9, tMRD 12 ns -> 1.
    // Entry: {cmd[3:0], done, length in cycles}.
    localparam logic [12:0] SEQ [10] = '{
        {C_NOP, 1'b0, 8'd1},
        {C_PRE, 1'b0, 8'd1},
        {C_NOP, 1'b0, 8'd2},
        {C_REF, 1'b0, 8'd1},
        {C_NOP, 1'b0, 8'd9},
        {C_REF, 1'b0, 8'd1},
        {C_NOP, 1'b0, 8'd9},
        {C_MRS, 1'b0, 8'd1},
        {C_NOP, 1'b0, 8'd1},
        {C_NOP, 1'b1, 8'd4}
    };

    // Fast instance: tRP 8 ns and tMRD 4 ns -> no wait, tRFC 15 ns -> 1 NOP.
    // Entry: {cmd[3:0], done}, one cycle each.
    localparam logic [4:0] FAST_SEQ [8] = '{
        {C_NOP, 1'b0}, {C_PRE, 1'b0}, {C_REF, 1'b0}, {C_NOP, 1'b0},
        {C_REF, 1'b0}, {C_NOP, 1'b0}, {C_MRS, 1'b0}, {C_NOP, 1'b1}
    };

    logic clk = 1'b0;
    logic rst;
    logic stable;

    logic        m_cke, m_cs, m_ras, m_cas, m_we, m_done;
    logic [12:0] m_addr;
    logic [1:0]  m_ba;
    logic        f_cke, f_cs, f_ras, f_cas, f_we, f_done;
    logic [12:0] f_addr;
    logic [1:0]  f_ba;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    dram_init_seq u_dram_init_seq (
        .clk(clk), .rst(rst), .stable_i(stable),
        .cke_o(m_cke), .cs_n_o(m_cs), .ras_n_o(m_ras), .cas_n_o(m_cas), .we_n_o(m_we),
        .addr_o(m_addr), .ba_o(m_ba), .init_done_o(m_done)
    );

    dram_init_seq #(
        .CLK_PERIOD_PS(8000), .T_RP_PS(8000), .T_RFC_PS(15000), .T_MRD_PS(4000),
        .ADDR_W(13), .BANK_W(2), .MODE_VALUE(13'h0155)
    ) u_dram_init_seq_fast (
        .clk(clk), .rst(rst), .stable_i(stable),
        .cke_o(f_cke), .cs_n_o(f_cs), .ras_n_o(f_ras), .cas_n_o(f_cas), .we_n_o(f_we),
        .addr_o(f_addr), .ba_o(f_ba), .init_done_o(f_done)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [12:0] exp_addr(input logic [3:0] c, input logic [12:0] mv);
        if (c == C_PRE) return 13'h0400;
        if (c == C_MRS) return mv;
        return 13'h0000;
    endfunction

    task automatic check_reset_main(input string req);
        check(req, "main cke", 32'(m_cke), 32'd0);
        check(req, "main cmd", 32'({m_cs, m_ras, m_cas, m_we}), 32'(C_DES));
        check(req, "main addr/ba", 32'({m_addr, m_ba}), 32'd0);
        check(req, "main done", 32'(m_done), 32'd0);
    endtask

    initial begin
        rst = 1'b1;
        stable = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values on both instances
        check_reset_main("R1");
        check("R1", "fast cke/cmd", 32'({f_cke, f_cs, f_ras, f_cas, f_we}), 32'({1'b0, C_DES}));
        rst = 1'b0;
        @(negedge clk);
        check_reset_main("R1");
        // R2: stays idle while stabilization is low
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R2", "idle cke/cmd", 32'({m_cke, m_cs, m_ras, m_cas, m_we}), 32'({1'b0, C_DES}));
        end
        stable = 1'b1;
        // R3, R4, R5, R7, R8, R9: walk the expected sequence table
        for (int s = 0; s < 10; s++) begin
            for (int j = 0; j < int'(SEQ[s][7:0]); j++) begin
                @(negedge clk);
                check((s < 2) ? "R3" : "R4", "cmd",
                      32'({m_cs, m_ras, m_cas, m_we}), 32'(SEQ[s][12:9]));
                check("R5", "cke", 32'(m_cke), 32'd1);
                check("R9", "done", 32'(m_done), 32'(SEQ[s][8]));
                check((SEQ[s][12:9] == C_MRS) ? "R8" : "R7", "addr",
                      32'(m_addr), 32'(exp_addr(SEQ[s][12:9], MODE)));
                check("R7", "bank", 32'(m_ba), 32'd0);
            end
        end
        // R9: stabilization input ignored once ready
        stable = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9", "ready hold", 32'({m_done, m_cke, m_cs, m_ras, m_cas, m_we}),
                  32'({2'b11, C_NOP}));
        end
        // R10: reset from ready, restart, then reset inside a refresh wait
        rst = 1'b1;
        @(negedge clk);
        check_reset_main("R10");
        rst = 1'b0;
        stable = 1'b1;
        @(negedge clk);
        check("R10", "restart nop", 32'({m_cke, m_cs, m_ras, m_cas, m_we}), 32'({1'b1, C_NOP}));
        @(negedge clk);
        check("R10", "restart pre", 32'({m_cs, m_ras, m_cas, m_we}), 32'(C_PRE));
        repeat (4) @(negedge clk);
        check("R10", "in refresh wait", 32'({m_cs, m_ras, m_cas, m_we}), 32'(C_NOP));
        rst = 1'b1;
        @(negedge clk);
        check_reset_main("R10");
        stable = 1'b0;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_main("R2");
        // R6: fast instance with skipped waits
        stable = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R6", "fast cmd", 32'({f_cs, f_ras, f_cas, f_we}), 32'(FAST_SEQ[k][4:1]));
            check("R6", "fast done", 32'(f_done), 32'(FAST_SEQ[k][0]));
            check("R8", "fast addr", 32'(f_addr), 32'(exp_addr(FAST_SEQ[k][4:1], 13'h0155)));
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule